// File: doc/BRIEF.md
# Two-Source Byte Shuffle Unit

This block is one execution stage for a 128-bit vector byte shuffle. Each cycle it can take one 32-bit instruction word and three 128-bit operands: two data sources and one selector vector. It checks that the word encodes the shuffle operation. It then builds a 16-byte result in which every byte is copied from one position of the 32-byte string formed by placing the first source ahead of the second. The result comes out one clock later. The destination and operand register numbers decoded from the word come out with it, so that the surrounding pipeline can write the result back.

Bytes are numbered from the most significant end. Byte 0 is bits 127:120, and byte 15 is bits 7:0. In the selector vector, each byte picks the source for the result byte at the same position. Only the five least significant bits of a selector byte count. Word bit positions in this brief use the same most-significant-first numbering, so word bit 0 is `in_insn[31]`.

Both edges of the stage are valid/ready streams. An input is accepted on a clock edge where `in_valid` and `in_ready` are both high. A result is consumed on an edge where `out_valid` and `out_ready` are both high. While a result waits with `out_ready` low, the stage holds it unchanged and deasserts `in_ready`. `in_ready` depends combinationally on `out_ready`, which lets one transfer per cycle pass through under steady flow.

Top module: `byte_shuffle_unit`

## Requirements
- R1: For a legal word, a selector index below 16 makes result byte i equal to byte [index] of source A.
- R2: For a legal word, a selector index from 16 to 31 makes result byte i equal to byte [index−16] of source B.
- R3: The selector index is the low five bits of selector byte i, that is bits 4:0 of that byte. Bits 7:5 have no effect on the result.
- R4: The word is legal only when `in_insn[31:26]` is 4 and `in_insn[5:0]` is 43 (0x1000002B with all register fields zero). Any other word sets `out_illegal` and forces `out_result` to zero.
- R5: The register-number outputs carry the following word fields: destination from `in_insn[25:21]`, source A from `[20:16]`, source B from `[15:11]` and selector from `[10:6]`. These fields are passed through for illegal words as well.
- R6: An input accepted on one edge shows up on the outputs with `out_valid` high right after that edge.
- R7: While `out_valid` is high and `out_ready` is low, the stage keeps `in_ready` low and holds every output stable. `in_ready` is high whenever the output register is empty or is being drained.
- R8: A synchronous active-high `rst` clears `out_valid`.
- R9: When source A and source B carry the same register number, the unit applies no special handling. It still selects from the two operand vectors as given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Stage can take an input this cycle |
| in_insn | input | 32 | Instruction word |
| in_src_a | input | 128 | First source, supplies bytes 0..15 of the 32-byte string |
| in_src_b | input | 128 | Second source, supplies bytes 16..31 of the 32-byte string |
| in_sel | input | 128 | Selector vector, one index byte per result byte |
| out_valid | output | 1 | Result held for the consumer |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 128 | Shuffled result, zero for an illegal word |
| out_illegal | output | 1 | Word did not decode as the shuffle operation |
| out_dst_reg | output | 5 | Destination register number |
| out_a_reg | output | 5 | Source A register number |
| out_b_reg | output | 5 | Source B register number |
| out_sel_reg | output | 5 | Selector register number |

## Verification
The bench builds the unit with the default `BYTES` of 16. That gives 5-bit indices and a 32-byte selection string, so every index value from 0 to 31 and every combination of ignored upper selector bits can be reached with random operands. Directed cases cover the identity selector, an all-from-B selector, and selectors whose upper bits are all set. They also cover each of the two opcode fields going wrong on its own, and a held output under back-pressure while a second input waits.

// File: rtl/shuf_pkg.sv
package shuf_pkg;
  localparam int INSN_W = 32;
  localparam int OPC_W  = 6;
  localparam int REG_W  = 5;
  localparam logic [OPC_W-1:0] PRIMARY_OPC  = 6'd4;
  localparam logic [OPC_W-1:0] EXTENDED_OPC = 6'd43;

  typedef struct packed {
    logic             legal;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] ra;
    logic [REG_W-1:0] rb;
    logic [REG_W-1:0] rsel;
  } decoded_t;
endpackage

// File: rtl/shuf_decode.sv
module shuf_decode
  import shuf_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output decoded_t          dec
);
  // Word fields, most-significant bit first: primary opcode, four
  // register numbers, extended opcode.
  logic [OPC_W-1:0] primary;
  logic [OPC_W-1:0] extended;

  always_comb begin
    primary    = insn[INSN_W-1 -: OPC_W];
    extended   = insn[OPC_W-1:0];
    dec.dst    = insn[INSN_W-OPC_W-1 -: REG_W];
    dec.ra     = insn[INSN_W-OPC_W-REG_W-1 -: REG_W];
    dec.rb     = insn[INSN_W-OPC_W-2*REG_W-1 -: REG_W];
    dec.rsel   = insn[INSN_W-OPC_W-3*REG_W-1 -: REG_W];
    dec.legal  = (primary == PRIMARY_OPC) && (extended == EXTENDED_OPC);
  end
endmodule

// File: rtl/shuf_byte_select.sv
module shuf_byte_select #(
  parameter int BYTES = 16,
  localparam int DATA_W = 8 * BYTES,
  localparam int IDX_W  = $clog2(2 * BYTES)
) (
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] sel,
  output logic [DATA_W-1:0] result
);
  // A ahead of B: string byte k sits at the top for k = 0.
  logic [2*DATA_W-1:0] joined;
  assign joined = {src_a, src_b};

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    logic [7:0]       sel_byte;
    logic [IDX_W-1:0] idx;
    logic             unused_hi;

    assign sel_byte  = sel[DATA_W-1-8*i -: 8];
    assign idx       = sel_byte[IDX_W-1:0];
    assign unused_hi = ^sel_byte[7:IDX_W];

    always_comb begin
      result[DATA_W-1-8*i -: 8] = '0;
      for (int k = 0; k < 2 * BYTES; k++) begin
        if (idx == IDX_W'(k))
          result[DATA_W-1-8*i -: 8] = joined[2*DATA_W-1-8*k -: 8];
      end
    end
  end
endmodule

// File: rtl/byte_shuffle_unit.sv
module byte_shuffle_unit
  import shuf_pkg::*;
#(
  parameter int BYTES = 16,
  localparam int DATA_W = 8 * BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] in_insn,
  input  logic [DATA_W-1:0] in_src_a,
  input  logic [DATA_W-1:0] in_src_b,
  input  logic [DATA_W-1:0] in_sel,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_illegal,
  output logic [REG_W-1:0]  out_dst_reg,
  output logic [REG_W-1:0]  out_a_reg,
  output logic [REG_W-1:0]  out_b_reg,
  output logic [REG_W-1:0]  out_sel_reg
);
  decoded_t          dec;
  logic [DATA_W-1:0] shuffled;

  shuf_decode u_decode (
    .insn (in_insn),
    .dec  (dec)
  );

  shuf_byte_select #(.BYTES(BYTES)) u_select (
    .src_a  (in_src_a),
    .src_b  (in_src_b),
    .sel    (in_sel),
    .result (shuffled)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_ready && in_valid) begin
      out_result  <= dec.legal ? shuffled : '0;
      out_illegal <= !dec.legal;
      out_dst_reg <= dec.dst;
      out_a_reg   <= dec.ra;
      out_b_reg   <= dec.rb;
      out_sel_reg <= dec.rsel;
    end
  end
endmodule

// File: rtl/shuf_checker.sv
module shuf_checker
  import shuf_pkg::*;
#(
  parameter int BYTES = 16,
  localparam int DATA_W = 8 * BYTES
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [INSN_W-1:0] in_insn,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic              out_illegal,
  input logic [REG_W-1:0]  out_dst_reg
);
  assert_accept_valid_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  assert_stall_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  assert_stall_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_result) && $stable(out_illegal) && $stable(out_dst_reg)));

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> !out_valid);

  assert_illegal_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (out_result == '0));

  assert_bad_opcode_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (in_insn[INSN_W-1 -: OPC_W] != PRIMARY_OPC)) |=> out_illegal);

  assert_field_pass_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_dst_reg == $past(in_insn[25:21])));
endmodule

bind byte_shuffle_unit shuf_checker #(.BYTES(BYTES)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_insn     (in_insn),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_result  (out_result),
  .out_illegal (out_illegal),
  .out_dst_reg (out_dst_reg)
);

// File: tb/test_byte_shuffle_unit.sv
module test_byte_shuffle_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_insn = '0;
  logic [127:0] in_src_a = '0, in_src_b = '0, in_sel = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_result;
  logic         out_illegal;
  logic [4:0]   out_dst_reg, out_a_reg, out_b_reg, out_sel_reg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  byte_shuffle_unit i_byte_shuffle_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_src_a(in_src_a), .in_src_b(in_src_b), .in_sel(in_sel),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_illegal(out_illegal), .out_dst_reg(out_dst_reg), .out_a_reg(out_a_reg),
    .out_b_reg(out_b_reg), .out_sel_reg(out_sel_reg)
  );

  function automatic logic [7:0] byte_at(logic [127:0] v, int k);
    return 8'(v >> (8 * (15 - k)));
  endfunction

  function automatic logic [127:0] ref_shuffle(logic [127:0] a, logic [127:0] b, logic [127:0] c);
    logic [127:0] r = '0;
    for (int i = 0; i < 16; i++) begin
      int k = int'(byte_at(c, i) & 8'h1f);
      r = {r[119:0], (k < 16) ? byte_at(a, k) : byte_at(b, k - 16)};
    end
    return r;
  endfunction

  function automatic logic [31:0] mk(logic [5:0] p, logic [4:0] d, logic [4:0] ra,
                                     logic [4:0] rb, logic [4:0] rc, logic [5:0] x);
    return {p, d, ra, rb, rc, x};
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_one(string req, logic [31:0] w, logic [127:0] a, logic [127:0] b, logic [127:0] c);
    logic legal = (w[31:26] == 6'd4) && (w[5:0] == 6'd43);
    @(negedge clk);
    in_valid = 1'b1; in_insn = w; in_src_a = a; in_src_b = b; in_sel = c; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R6 valid"}, 128'(out_valid), 128'd1);
    check({req, " R4 flag"}, 128'(out_illegal), 128'(!legal));
    check({req, " result"}, out_result, legal ? ref_shuffle(a, b, c) : 128'd0);
    check({req, " R5 regs"}, 128'({out_dst_reg, out_a_reg, out_b_reg, out_sel_reg}),
          128'(w[25:6]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] a, b, c, ident, fromb, hiset;
    logic [127:0] res1;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R8 reset out_valid", 128'(out_valid), 128'd0);
    check("R7 ready when empty", 128'(in_ready), 128'd1);
    rst = 1'b0;

    a = 128'h000102030405060708090a0b0c0d0e0f;
    b = 128'hf0f1f2f3f4f5f6f7f8f9fafbfcfdfeff;
    ident = a;
    run_one("R1 identity", mk(6'd4, 5'd1, 5'd2, 5'd3, 5'd4, 6'd43), a, b, ident);
    check("R1 identity equals A", out_result, a);
    fromb = 128'h101112131415161718191a1b1c1d1e1f;
    run_one("R2 all from B", mk(6'd4, 5'd31, 5'd0, 5'd30, 5'd15, 6'd43), a, b, fromb);
    check("R2 all from B equals B", out_result, b);
    hiset = 128'hff_e0_ff_e0_ef_f0_f5_e5_a3_c7_21_4e_7b_9c_d2_3f;
    run_one("R3 upper bits set", mk(6'd4, 5'd5, 5'd6, 5'd7, 5'd8, 6'd43), rnd128(), rnd128(), hiset);
    c = rnd128();
    a = rnd128(); b = rnd128();
    run_one("R3 base", mk(6'd4, 5'd9, 5'd1, 5'd2, 5'd3, 6'd43), a, b, c & {16{8'h1f}});
    res1 = out_result;
    run_one("R3 hi flipped", mk(6'd4, 5'd9, 5'd1, 5'd2, 5'd3, 6'd43), a, b, c | {16{8'he0}});
    check("R3 upper bits ignored", out_result, res1);
    run_one("R4 bad primary", 32'h1400002B, rnd128(), rnd128(), rnd128());
    run_one("R4 bad extended", mk(6'd4, 5'd3, 5'd3, 5'd3, 5'd3, 6'd42), rnd128(), rnd128(), rnd128());
    run_one("R4 bare word", 32'h1000002B, a, b, c);
    a = rnd128(); b = rnd128();
    run_one("R9 same reg", mk(6'd4, 5'd2, 5'd7, 5'd7, 5'd1, 6'd43), a, b, rnd128());

    // R7 back-pressure with a second input waiting
    @(negedge clk);
    a = rnd128(); b = rnd128(); c = rnd128();
    in_valid = 1'b1; in_insn = mk(6'd4, 5'd1, 5'd1, 5'd1, 5'd1, 6'd43);
    in_src_a = a; in_src_b = b; in_sel = c; out_ready = 1'b0;
    @(negedge clk);
    check("R7 stall valid", 128'(out_valid), 128'd1);
    check("R7 stall ready low", 128'(in_ready), 128'd0);
    in_src_a = rnd128(); in_src_b = rnd128(); in_sel = rnd128();
    in_insn = mk(6'd4, 5'd2, 5'd2, 5'd2, 5'd2, 6'd43);
    @(negedge clk);
    check("R7 stall holds result", out_result, ref_shuffle(a, b, c));
    check("R7 stall holds reg", 128'(out_dst_reg), 128'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 second taken", out_result, ref_shuffle(in_src_a, in_src_b, in_sel));
    check("R7 second reg", 128'(out_dst_reg), 128'd2);
    @(negedge clk);
    check("R7 drained", 128'(out_valid), 128'd0);

    for (int n = 0; n < 300; n++) begin
      logic [31:0] w = $urandom;
      w[31:26] = 6'd4;
      if (($urandom % 8) != 0) w[5:0] = 6'd43;
      run_one("R1 R2 random", w, rnd128(), rnd128(), rnd128());
    end

    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 reset clears", 128'(out_valid), 128'd0);
    rst = 1'b0;

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule